// File: doc/BRIEF.md
# Arithmetic-coder byte emitter with carry and bit stuffing

This block is the output end of a binary arithmetic coder. The interval unit next to it owns the code register C and the interval A. Each time it renormalizes, it hands this block the current code value and the number of left shifts to apply. The block applies the shifts while keeping its own bit counter. Each time the counter runs out, it performs a byte-out. A byte-out releases the byte held in the 8-bit byte buffer, folds any carry from bit 27 of C into that byte, and reloads the buffer from the top of C. When the released byte is 0xFF, one bit is stuffed. The block then returns the adjusted code value and counter.

One renormalization request can cross the counter boundary twice, so up to two bytes can leave in one cycle. A flush command ends the code stream. It first raises the low bits of C as far as the interval allows, then performs two full byte-outs, and finally releases the buffer unless it holds 0xFF. A flush can therefore produce three bytes in one cycle. The bytes produced by one request appear together, one cycle after the request, packed from the lowest lane upward.

A three-state machine tracks the emitter: ST_FRESH (the buffer still holds its dummy start value), ST_RUN (the buffer holds a real byte) and ST_DONE (the stream has been flushed). Its transitions are:
- T_FIRST_OUT: ST_FRESH to ST_RUN, on a step request that performs at least one byte-out.
- T_FLUSH_FRESH: ST_FRESH to ST_DONE, on a flush.
- T_FLUSH_RUN: ST_RUN to ST_DONE, on a flush.
- T_HOLD: ST_DONE stays in ST_DONE until reset.

Top module: `mq_byte_emitter`

## Requirements
- R1: After reset, ct_out is 12, c_out is 0, out_cnt is 0 and the byte buffer holds 0x00.
- R2: A step whose shift count stays below ct_out returns c_out = (c_in << shift_n) truncated to 28 bits and ct_out reduced by shift_n, with no byte produced.
- R3: At a byte-out where the buffer is not 0xFF and bit 27 of the shifted C is clear, the buffer byte is emitted, the buffer reloads from C bits 26:19, C keeps only bits 18:0, and the counter becomes 8.
- R4: At a byte-out where the buffer is 0xFF, 0xFF is emitted, the buffer reloads from C bits 27:20, C keeps only bits 19:0, and the counter becomes 7 (one stuffed bit).
- R5: At a byte-out where the buffer is not 0xFF and bit 27 of C is set, buffer+1 is emitted. If buffer+1 is 0xFF, bit 27 is cleared and the R4 reload applies (counter 7). Otherwise the R3 reload applies (counter 8).
- R6: The dummy start value of the buffer is never emitted: the first byte-out after reset produces no byte.
- R7: One step with shift_n up to 15 may perform two byte-outs. Both bytes appear in stream order in the same output cycle, the first in out_bytes[7:0] and the second in out_bytes[15:8], with out_cnt giving the count. Shifting then continues with the remaining count.
- R8: Flush computes T = C + a_in, sets C bits 15:0 to ones, and subtracts 0x8000 if C >= T. It then shifts by the counter and performs a byte-out, twice. Last, it emits the buffer unless that is 0xFF. This gives up to three packed bytes in one cycle.
- R9: After a flush, step and flush requests are ignored until reset: out_cnt stays 0, and c_out and ct_out hold.
- R10: Outputs update on the clock edge that samples a request. In any cycle after a clock edge that sampled no request, out_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Renormalization request |
| shift_n | input | 4 | Number of left shifts for a step |
| c_in | input | 28 | Code value before the shifts (or before flush) |
| flush | input | 1 | End-of-stream request (wins over step) |
| a_in | input | 16 | Current interval, used only by flush |
| c_out | output | 28 | Adjusted code value |
| ct_out | output | 4 | Bit counter after the request |
| out_cnt | output | 2 | Number of valid bytes in out_bytes this cycle |
| out_bytes | output | 24 | Packed bytes, lane k at bits 8k+7:8k, in stream order |

## Verification
A wrong buffer value does not show when it goes wrong. It shows at the next byte-out, which is at most 12 shifts later, as a wrong emitted byte or a wrong reload of C. A wrong counter shows at once in ct_out. It also shows as a byte-out in the wrong request, which changes out_cnt and shifts every later byte in the scoreboard. A state machine stuck in ST_FRESH drops the first real byte. A state machine that leaves ST_DONE produces bytes after a flush. Both are caught on the next request.

// File: rtl/mq_emit_pkg.sv
package mq_emit_pkg;
    localparam int CW        = 28;
    localparam int AW        = 16;
    localparam int BW        = 8;
    localparam int CTW       = 4;
    localparam int STEPS     = 2;
    localparam int LANES     = STEPS + 1;
    localparam int CARRY_BIT = CW - 1;
    localparam int NORM_LSB  = CARRY_BIT - BW;
    localparam int STUF_LSB  = NORM_LSB + 1;
    localparam int CT_START  = 12;
    localparam int CT_NORM   = BW;
    localparam int CT_STUF   = BW - 1;
    localparam int CNTW      = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        ST_FRESH = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2
    } emit_state_t;

    typedef struct packed {
        logic [CW-1:0]  c;
        logic [CTW-1:0] ct;
        logic [BW-1:0]  b;
        logic           fresh;
    } emit_ctx_t;
endpackage

// File: rtl/mq_emit_flushprep.sv
module mq_emit_flushprep
    import mq_emit_pkg::*;
(
    input  logic [CW-1:0] c_i,
    input  logic [AW-1:0] a_i,
    output logic [CW-1:0] c_o
);
    localparam logic [CW-1:0] LOW_ONES = CW'((64'd1 << AW) - 64'd1);
    localparam logic [CW-1:0] HALF_A   = CW'(64'd1 << (AW - 1));

    logic [CW:0]   top_bound;
    logic [CW-1:0] raised;

    always_comb begin
        top_bound = {1'b0, c_i} + {{(CW + 1 - AW){1'b0}}, a_i};
        raised    = c_i | LOW_ONES;
        if ({1'b0, raised} >= top_bound) begin
            c_o = raised - HALF_A;
        end else begin
            c_o = raised;
        end
    end
endmodule

// File: rtl/mq_emit_stage.sv
module mq_emit_stage
    import mq_emit_pkg::*;
(
    input  logic           full_i,
    input  emit_ctx_t      ctx_i,
    input  logic [CTW-1:0] rem_i,
    output emit_ctx_t      ctx_o,
    output logic [CTW-1:0] rem_o,
    output logic           fire_o,
    output logic           emit_vld_o,
    output logic [BW-1:0]  emit_byte_o
);
    localparam logic [CW-1:0] NORM_MASK = CW'((64'd1 << NORM_LSB) - 64'd1);
    localparam logic [CW-1:0] STUF_MASK = CW'((64'd1 << STUF_LSB) - 64'd1);
    localparam logic [CW-1:0] CARRY_CLR = ~(CW'(64'd1 << CARRY_BIT));

    logic [CTW-1:0] sh;
    logic [CW-1:0]  c_sh;
    logic [CW-1:0]  c_nocarry;
    logic [CTW-1:0] ct_sh;
    logic [BW-1:0]  b_inc;

    always_comb begin
        if (full_i) begin
            sh = ctx_i.ct;
        end else if (rem_i < ctx_i.ct) begin
            sh = rem_i;
        end else begin
            sh = ctx_i.ct;
        end
        c_sh        = ctx_i.c << sh;
        c_nocarry   = c_sh & CARRY_CLR;
        ct_sh       = ctx_i.ct - sh;
        fire_o      = (ct_sh == '0);
        b_inc       = ctx_i.b + 1'b1;
        ctx_o       = '{c: c_sh, ct: ct_sh, b: ctx_i.b, fresh: ctx_i.fresh};
        emit_byte_o = ctx_i.b;
        if (fire_o) begin
            ctx_o.fresh = 1'b0;
            if (ctx_i.b == '1) begin
                ctx_o.b  = c_sh[CW-1 -: BW];
                ctx_o.c  = c_sh & STUF_MASK;
                ctx_o.ct = CTW'(CT_STUF);
            end else if (c_sh[CARRY_BIT]) begin
                emit_byte_o = b_inc;
                if (b_inc == '1) begin
                    ctx_o.b  = c_nocarry[CW-1 -: BW];
                    ctx_o.c  = c_nocarry & STUF_MASK;
                    ctx_o.ct = CTW'(CT_STUF);
                end else begin
                    ctx_o.b  = c_sh[CARRY_BIT-1 -: BW];
                    ctx_o.c  = c_sh & NORM_MASK;
                    ctx_o.ct = CTW'(CT_NORM);
                end
            end else begin
                ctx_o.b  = c_sh[CARRY_BIT-1 -: BW];
                ctx_o.c  = c_sh & NORM_MASK;
                ctx_o.ct = CTW'(CT_NORM);
            end
        end
        emit_vld_o = fire_o && !ctx_i.fresh;
        rem_o      = full_i ? '0 : (rem_i - sh);
    end
endmodule

// File: rtl/mq_emit_pack.sv
module mq_emit_pack #(
    parameter int LANES_P = 3,
    parameter int BW_P    = 8,
    localparam int CNTW_P = $clog2(LANES_P + 1)
) (
    input  logic [LANES_P-1:0]           vld_i,
    input  logic [LANES_P-1:0][BW_P-1:0] byte_i,
    output logic [CNTW_P-1:0]            cnt_o,
    output logic [LANES_P*BW_P-1:0]      bytes_o
);
    always_comb begin
        int idx;
        idx     = 0;
        bytes_o = '0;
        for (int k = 0; k < LANES_P; k++) begin
            if (vld_i[k]) begin
                bytes_o[idx*BW_P +: BW_P] = byte_i[k];
                idx = idx + 1;
            end
        end
        cnt_o = CNTW_P'(idx);
    end
endmodule

// File: rtl/mq_byte_emitter.sv
module mq_byte_emitter
    import mq_emit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [CTW-1:0]  shift_n,
    input  logic [CW-1:0]   c_in,
    input  logic            flush,
    input  logic [AW-1:0]   a_in,
    output logic [CW-1:0]   c_out,
    output logic [CTW-1:0]  ct_out,
    output logic [CNTW-1:0] out_cnt,
    output logic [LANES*BW-1:0] out_bytes
);
    emit_state_t st_q, st_d;
    logic [BW-1:0] b_q;
    logic          accept;

    logic [CW-1:0] c_flush, c_src, c_fin;
    logic [CTW-1:0] ct_fin;
    emit_ctx_t      ctx [0:STEPS];
    logic [CTW-1:0] rem [0:STEPS];
    logic [STEPS-1:0] fired;
    logic [LANES-1:0] lane_vld;
    logic [LANES-1:0][BW-1:0] lane_byte;
    logic [CNTW-1:0]     pk_cnt;
    logic [LANES*BW-1:0] pk_bytes;
    logic [CTW-1:0] rem_tail, ct_tail;

    assign accept = (step || flush) && (st_q != ST_DONE);

    mq_emit_flushprep u_prep (
        .c_i (c_in),
        .a_i (a_in),
        .c_o (c_flush)
    );

    assign c_src  = flush ? c_flush : c_in;
    assign ctx[0] = '{c: c_src, ct: ct_out, b: b_q, fresh: (st_q == ST_FRESH)};
    assign rem[0] = flush ? '0 : shift_n;

    generate
        for (genvar gi = 0; gi < STEPS; gi++) begin : g_stage
            mq_emit_stage u_stage (
                .full_i      (flush),
                .ctx_i       (ctx[gi]),
                .rem_i       (rem[gi]),
                .ctx_o       (ctx[gi+1]),
                .rem_o       (rem[gi+1]),
                .fire_o      (fired[gi]),
                .emit_vld_o  (lane_vld[gi]),
                .emit_byte_o (lane_byte[gi])
            );
        end
    endgenerate

    assign lane_vld[LANES-1]  = flush && (ctx[STEPS].b != '1);
    assign lane_byte[LANES-1] = ctx[STEPS].b;

    assign rem_tail = rem[STEPS];
    assign ct_tail  = ctx[STEPS].ct;
    assign c_fin    = ctx[STEPS].c << rem_tail;
    assign ct_fin   = ct_tail - rem_tail;

    mq_emit_pack #(.LANES_P(LANES), .BW_P(BW)) u_pack (
        .vld_i   (lane_vld),
        .byte_i  (lane_byte),
        .cnt_o   (pk_cnt),
        .bytes_o (pk_bytes)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FRESH: begin
                if (flush) begin
                    st_d = ST_DONE;
                end else if (step && (|fired)) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (flush) begin
                    st_d = ST_DONE;
                end
            end
            ST_DONE: st_d = ST_DONE;
            default: st_d = ST_FRESH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_FRESH;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_out     <= '0;
            ct_out    <= CTW'(CT_START);
            b_q       <= '0;
            out_cnt   <= '0;
            out_bytes <= '0;
        end else if (accept) begin
            c_out     <= c_fin;
            ct_out    <= ct_fin;
            b_q       <= ctx[STEPS].b;
            out_cnt   <= pk_cnt;
            out_bytes <= pk_bytes;
        end else begin
            out_cnt   <= '0;
        end
    end
endmodule

module mq_byte_emitter_chk
    import mq_emit_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            step,
    input logic            flush,
    input emit_state_t     st_q,
    input logic [CW-1:0]   c_out,
    input logic [CTW-1:0]  ct_out,
    input logic [CNTW-1:0] out_cnt,
    input logic [CTW-1:0]  rem_tail,
    input logic [CTW-1:0]  ct_tail
);
    AST_CT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (ct_out != '0) && (ct_out <= CTW'(CT_START))); // R2
    AST_IDLE_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n) !(step || flush) |=> (out_cnt == '0)); // R10
    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_DONE) |=> (out_cnt == '0) && $stable(c_out) && $stable(ct_out)); // R9
    AST_FRESH_NO_DUMMY: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_FRESH) && step && !flush |=> (out_cnt <= CNTW'(1))); // R6
    AST_STEP_TWO_MAX: assert property (@(posedge clk) disable iff (!rst_n) step && !flush |=> (out_cnt <= CNTW'(2))); // R7
    AST_TAIL_FITS: assert property (@(posedge clk) disable iff (!rst_n) step && !flush && (st_q != ST_DONE) |-> (rem_tail < ct_tail)); // R7
    AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (st_q == ST_DONE)); // R8
endmodule

bind mq_byte_emitter mq_byte_emitter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .flush    (flush),
    .st_q     (st_q),
    .c_out    (c_out),
    .ct_out   (ct_out),
    .out_cnt  (out_cnt),
    .rem_tail (rem_tail),
    .ct_tail  (ct_tail)
);

// File: tb/mq_byte_emitter_test.sv
module mq_byte_emitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [3:0]  shift_n = '0;
    logic [27:0] c_in = '0;
    logic        flush = 1'b0;
    logic [15:0] a_in = '0;
    logic [27:0] c_out;
    logic [3:0]  ct_out;
    logic [1:0]  out_cnt;
    logic [23:0] out_bytes;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    string cur_tag = "R1";

    logic [7:0]  exp_q[$];
    logic [31:0] mc;
    logic [7:0]  mb;
    int          mct;
    bit          mfresh, mdone;

    always #5 clk = ~clk;

    mq_byte_emitter uut (
        .clk(clk), .rst_n(rst_n), .step(step), .shift_n(shift_n), .c_in(c_in),
        .flush(flush), .a_in(a_in), .c_out(c_out), .ct_out(ct_out),
        .out_cnt(out_cnt), .out_bytes(out_bytes)
    );

    task automatic chk_eq(string tag, string what, longint got, longint exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic void m_push(logic [7:0] x);
        if (!mfresh) exp_q.push_back(x);
    endfunction

    function automatic void m_byteout();
        if (mb == 8'hFF) begin
            m_push(mb);
            mb = mc[27:20]; mc = mc & 32'h000F_FFFF; mct = 7;
        end else if (mc[27]) begin
            mb = mb + 8'd1;
            if (mb == 8'hFF) begin
                mc = mc & 32'h07FF_FFFF;
                m_push(mb);
                mb = mc[27:20]; mc = mc & 32'h000F_FFFF; mct = 7;
            end else begin
                m_push(mb);
                mb = mc[26:19]; mc = mc & 32'h0007_FFFF; mct = 8;
            end
        end else begin
            m_push(mb);
            mb = mc[26:19]; mc = mc & 32'h0007_FFFF; mct = 8;
        end
        mfresh = 0;
    endfunction

    function automatic void m_step(logic [27:0] c, int n);
        mc = {4'b0, c};
        for (int i = 0; i < n; i++) begin
            mc = (mc << 1) & 32'h0FFF_FFFF;
            mct = mct - 1;
            if (mct == 0) m_byteout();
        end
    endfunction

    function automatic void m_flush(logic [27:0] c, logic [15:0] a);
        longint t;
        longint cc;
        cc = longint'(c);
        t = cc + longint'(a);
        cc = cc | 64'hFFFF;
        if (cc >= t) cc = cc - 64'h8000;
        mc = 32'(cc);
        for (int k = 0; k < 2; k++) begin
            mc = (mc << mct) & 32'h0FFF_FFFF;
            m_byteout();
        end
        if (mb != 8'hFF) m_push(mb);
        mdone = 1;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < int'(out_cnt); k++) begin
                nchk++;
                if (exp_q.size() == 0) begin
                    nerr++;
                    $display("FAIL %s unexpected byte: got %0h expected none", cur_tag, out_bytes[k*8 +: 8]);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (out_bytes[k*8 +: 8] != e) begin
                        nerr++;
                        $display("FAIL %s byte lane %0d: got %0h expected %0h", cur_tag, k, out_bytes[k*8 +: 8], e);
                    end
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        chk_eq("R7", "bytes still owed at reset", exp_q.size(), 0);
        exp_q.delete();
        rst_n = 1'b0; step = 0; flush = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mc = 0; mb = 0; mct = 12; mfresh = 1; mdone = 0;
    endtask

    task automatic req(bit fl, logic [27:0] c, logic [3:0] n, logic [15:0] a, string tag);
        @(negedge clk);
        cur_tag = tag;
        step = !fl; flush = fl; c_in = c; shift_n = n; a_in = a;
        if (!mdone) begin
            if (fl) m_flush(c, a);
            else m_step(c, int'(n));
        end
        @(negedge clk);
        step = 0; flush = 0;
        chk_eq(tag, "c_out", longint'(c_out), longint'(mc));
        chk_eq(tag, "ct_out", longint'(ct_out), longint'(mct));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk_eq("R1", "c_out", longint'(c_out), 0);
        chk_eq("R1", "ct_out", longint'(ct_out), 12);
        chk_eq("R1", "out_cnt", longint'(out_cnt), 0);

        // R2: shift without byte-out
        req(0, 28'h123, 4'd5, 16'h0, "R2");
        chk_eq("R2", "c_out literal", longint'(c_out), 28'h2460);
        chk_eq("R2", "out_cnt", longint'(out_cnt), 0);
        @(negedge clk);
        chk_eq("R10", "quiet cycle out_cnt", longint'(out_cnt), 0);

        // R6 then R3: dummy not emitted, then normal byte-out
        do_reset();
        req(0, 28'h2D00, 4'd12, 16'h0, "R6");
        req(0, 28'h1000, 4'd8, 16'h0, "R3");
        chk_eq("R3", "out_cnt", longint'(out_cnt), 1);
        chk_eq("R3", "byte", longint'(out_bytes[7:0]), 8'h5A);

        // R4: buffer 0xFF stuffs a bit
        do_reset();
        req(0, 28'h7F80, 4'd12, 16'h0, "R6");
        req(0, 28'h12345, 4'd8, 16'h0, "R4");
        chk_eq("R4", "byte", longint'(out_bytes[7:0]), 8'hFF);
        chk_eq("R4", "ct literal", longint'(ct_out), 7);
        chk_eq("R4", "c literal", longint'(c_out), 28'h34500);

        // R5: carry turning 0xFE into 0xFF
        do_reset();
        req(0, 28'h7F00, 4'd12, 16'h0, "R6");
        req(0, 28'h80000, 4'd8, 16'h0, "R5");
        chk_eq("R5", "byte", longint'(out_bytes[7:0]), 8'hFF);
        chk_eq("R5", "ct literal", longint'(ct_out), 7);
        // R5: carry into a non-0xFF byte
        do_reset();
        req(0, 28'h2D00, 4'd12, 16'h0, "R6");
        req(0, 28'h80000, 4'd8, 16'h0, "R5");
        chk_eq("R5", "byte", longint'(out_bytes[7:0]), 8'h5B);

        // R7: two byte-outs in one step, then R8 flush and R9 ignore
        do_reset();
        req(0, 28'h2D00, 4'd12, 16'h0, "R6");
        req(0, 28'h3, 4'd7, 16'h0, "R2");
        req(0, 28'h1AB, 4'd9, 16'h0, "R7");
        chk_eq("R7", "out_cnt", longint'(out_cnt), 2);
        req(1, c_out, 4'd0, 16'h8000, "R8");
        req(0, 28'h55, 4'd3, 16'h0, "R9");
        chk_eq("R9", "out_cnt", longint'(out_cnt), 0);
        req(1, 28'h0, 4'd0, 16'h9000, "R9");
        chk_eq("R9", "out_cnt after second flush", longint'(out_cnt), 0);

        // R7/R8: random streams checked against the bit-serial model
        for (int r = 0; r < 15; r++) begin
            do_reset();
            for (int s = 0; s < 250; s++) begin
                int lim;
                logic [27:0] cn;
                lim = (mct >= 2) ? 15 : 14;
                cn = 28'((mc + 32'($urandom_range(0, 16'hFFFF))) & 32'h0FFF_FFFF);
                req(0, cn, 4'($urandom_range(0, lim)), 16'h0, "R7");
            end
            req(1, 28'(mc), 4'd0, 16'($urandom_range(16'h8000, 16'hFFFF)), "R8");
            req(0, 28'h1, 4'd1, 16'h0, "R9");
        end

        @(negedge clk);
        chk_eq("R8", "bytes still owed at end", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule